// File: doc/BRIEF.md
# Dual-Issue Pair Legality Checker

This block sits at the head of an in-order issue window and decides, every cycle, whether the two oldest decoded instructions may enter a two-wide pipeline together. Each of the two slots carries a descriptor built by the decoder: a class code, a store flag, integer and floating-point register operands (floating-point registers are named by doubleword number plus a two-bit word mask), carry read and write flags and a word address. A one-cycle indication from the fetch stage announces that the next instruction to reach the older slot is the target of a taken branch.

The outputs are two mutually exclusive strobes. `issue_both` releases both slots. `issue_first` releases only the older slot; the younger one then moves into the older slot for the next cycle's decision. Two registered flags carry state across cycles: one marks the next older-slot instruction as a branch delay slot, and the other marks it as a branch target. Fetch raises `branch_taken` in the cycle before the target reaches the older slot.

Class codes: 0 floating-point op, 1 load/store, 2 integer ALU, 3 shift/extract/deposit, 4 may-nullify-successor, 5 register/external branch, 6 other branch, 7 floating-point test/status, 8 system control. Word mask bit 0 is the low word of a doubleword and bit 1 the high word; a mask of zero means no such operand.

Top module: `pair_issue_checker`

## Requirements
- R1: `issue_both` is high only when both slots are valid and every rule below passes. `issue_first` is high exactly when slot 0 is valid and `issue_both` is low. Both are low when slot 0 is invalid.
- R2: Pairing by class depends on the older class. After class 0 the younger may be 1, 2, 3, 4, 5 or 6. After 1 it may be 0, 2, 3, 4 or 6. After 2 it may be 0, 1, 2, 3, 4, 6 or 7. After 3 it may be 0, 1, 2 or 7. After 4 it may only be 0. Classes 5 to 8 in the older slot never pair.
- R3: A class 8 instruction never pairs, whichever slot it is in.
- R4: The pair is refused when a valid integer source of slot 1 equals a valid integer destination of slot 0.
- R5: The pair is refused when a floating-point source of slot 1 has the same register number as slot 0's floating-point destination and the two word masks share a bit. This does not apply when slot 0 is class 0 and slot 1 is a class 1 store.
- R6: In either order, a class 1 load that writes exactly one word of a register refuses to pair with a class 0 op that reads the other word of the same register.
- R7: In either order, a class 0 op and a class 1 load with nonzero destination masks and the same floating-point destination number do not pair.
- R8: The pair is refused when one slot may set the carry bits and the other reads them.
- R9: In the first issue cycle after an issue whose last released instruction was class 5 or 6, slot 0 issues alone.
- R10: In the first issue cycle after `branch_taken`, slot 0 issues alone if bit 0 of its word address is 1. An even address does not restrict pairing.
- R11: Reset clears both flags, so the first pair after reset is judged only by R1 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 2 | Slot holds an instruction (index 0 = older) |
| slot_class | input | 2x4 | Class code per slot |
| slot_store | input | 2 | Load/store slot is a store |
| int_rd_vld | input | 2 | Integer destination present |
| int_rd | input | 2x5 | Integer destination number |
| int_rs_vld | input | 2x2 | Integer source present, two per slot |
| int_rs | input | 2x2x5 | Integer source numbers |
| fp_rd_words | input | 2x2 | FP destination word mask |
| fp_rd | input | 2x5 | FP destination doubleword number |
| fp_rs_words | input | 2x2x2 | FP source word masks, two per slot |
| fp_rs | input | 2x2x5 | FP source doubleword numbers |
| carry_set | input | 2 | Slot may write carry/borrow bits |
| carry_use | input | 2 | Slot reads carry/borrow bits |
| slot_addr | input | 2x30 | Word address per slot |
| branch_taken | input | 1 | Next older-slot instruction is a taken-branch target |
| issue_both | output | 1 | Release both slots |
| issue_first | output | 1 | Release slot 0 only |

## Verification
The delay-slot flag and the branch-target flag can both be in force in the same cycle: a branch issues alone, and `branch_taken` is raised while its delay slot sits in slot 0. The next cycle then holds an odd-address target whose refusal has to come from the target rule once the delay flag has cleared. The bench builds this sequence on purpose, then repeats it with an even target address, and random runs with frequent branches and taken pulses create further overlaps. A reference model in the bench tracks both flags from the issue results and names the first rule that refuses each pair.

// File: rtl/issue_pair_pkg.sv
package issue_pair_pkg;

  localparam int CLS_W   = 4;
  localparam int NUM_CLS = 9;

  typedef enum logic [CLS_W-1:0] {
    IC_FLOP = 4'd0,
    IC_LDST = 4'd1,
    IC_FLEX = 4'd2,
    IC_MM   = 4'd3,
    IC_NUL  = 4'd4,
    IC_BV   = 4'd5,
    IC_BR   = 4'd6,
    IC_FSYS = 4'd7,
    IC_SYS  = 4'd8
  } iclass_e;

  // Bit i set: a younger instruction of class i may follow this older class.
  function automatic logic [NUM_CLS-1:0] younger_mask(input logic [CLS_W-1:0] older);
    logic [NUM_CLS-1:0] m;
    case (older)
      IC_FLOP: m = 9'b001111110;
      IC_LDST: m = 9'b001011101;
      IC_FLEX: m = 9'b011011111;
      IC_MM:   m = 9'b010000111;
      IC_NUL:  m = 9'b000000001;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic is_branch(input logic [CLS_W-1:0] c);
    return (c == IC_BV) || (c == IC_BR);
  endfunction

  function automatic logic single_word(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic words_share(input logic [1:0] a, input logic [1:0] b);
    return |(a & b);
  endfunction

endpackage

// File: rtl/pair_class_matrix.sv
module pair_class_matrix
  import issue_pair_pkg::*;
(
  input  logic [CLS_W-1:0] cls_old,
  input  logic [CLS_W-1:0] cls_young,
  output logic             class_ok
);

  logic [NUM_CLS-1:0] row;
  logic               young_in_range;

  assign row            = younger_mask(cls_old);
  assign young_in_range = cls_young < CLS_W'(NUM_CLS);

  always_comb begin
    class_ok = 1'b0;
    if (young_in_range) class_ok = row[cls_young];
  end

  // R3: the table itself never admits system control in either slot
  always_comb begin
    if (class_ok) begin
      a_r3_matrix_no_sys: assert (cls_old != IC_SYS && cls_young != IC_SYS);
    end
  end

endmodule

// File: rtl/pair_hazard_unit.sv
module pair_hazard_unit
  import issue_pair_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [1:0][CLS_W-1:0]              cls,
  input  logic [1:0]                         store,
  input  logic [1:0]                         int_rd_vld,
  input  logic [1:0][REG_W-1:0]              int_rd,
  input  logic [1:0][NUM_SRC-1:0]            int_rs_vld,
  input  logic [1:0][NUM_SRC-1:0][REG_W-1:0] int_rs,
  input  logic [1:0][1:0]                    fp_rd_words,
  input  logic [1:0][REG_W-1:0]              fp_rd,
  input  logic [1:0][NUM_SRC-1:0][1:0]       fp_rs_words,
  input  logic [1:0][NUM_SRC-1:0][REG_W-1:0] fp_rs,
  input  logic [1:0]                         carry_set,
  input  logic [1:0]                         carry_use,
  output logic                               raw_hit,
  output logic                               half_hit,
  output logic                               target_hit,
  output logic                               carry_hit
);

  logic [NUM_SRC-1:0] int_raw;
  logic [NUM_SRC-1:0] fp_raw;
  logic [1:0]         half_dir;
  logic               store_of_result;

  // Read-after-write from older slot 0 into younger slot 1, per source
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign int_raw[k] = int_rd_vld[0] && int_rs_vld[1][k] &&
                        (int_rs[1][k] == int_rd[0]);
    assign fp_raw[k]  = words_share(fp_rd_words[0], fp_rs_words[1][k]) &&
                        (fp_rs[1][k] == fp_rd[0]);
  end

  assign store_of_result = (cls[0] == IC_FLOP) && (cls[1] == IC_LDST) && store[1];
  assign raw_hit = (|int_raw) || ((|fp_raw) && !store_of_result);

  // Half-doubleword conflict, checked for both slot orders
  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int LD = d;
    localparam int FL = 1 - d;
    logic             load_one_word;
    logic [NUM_SRC-1:0] other_word_read;
    assign load_one_word = (cls[LD] == IC_LDST) && !store[LD] &&
                           single_word(fp_rd_words[LD]);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_rd
      assign other_word_read[k] = (fp_rs[FL][k] == fp_rd[LD]) &&
                                  words_share(fp_rs_words[FL][k], ~fp_rd_words[LD]);
    end
    assign half_dir[d] = load_one_word && (cls[FL] == IC_FLOP) && (|other_word_read);
  end
  assign half_hit = |half_dir;

  // Floating-point op and FP load aiming at the same register
  always_comb begin
    target_hit = 1'b0;
    if ((|fp_rd_words[0]) && (|fp_rd_words[1]) && (fp_rd[0] == fp_rd[1])) begin
      if (cls[0] == IC_FLOP && cls[1] == IC_LDST && !store[1]) target_hit = 1'b1;
      if (cls[1] == IC_FLOP && cls[0] == IC_LDST && !store[0]) target_hit = 1'b1;
    end
  end

  assign carry_hit = (carry_set[0] && carry_use[1]) || (carry_set[1] && carry_use[0]);

  // Younger destinations and older sources do not take part in these rules
  logic unused_operands;
  assign unused_operands = ^{int_rd_vld[1], int_rd[1], int_rs_vld[0], int_rs[0]};

endmodule

// File: rtl/issue_slot_state.sv
module issue_slot_state (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_any,
  input  logic last_is_branch,
  input  logic branch_taken,
  output logic delay_q,
  output logic target_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q  <= 1'b0;
      target_q <= 1'b0;
    end else begin
      if (issue_any) delay_q <= last_is_branch;
      if (branch_taken)   target_q <= 1'b1;
      else if (issue_any) target_q <= 1'b0;
    end
  end

  // R9: a released branch always arms the delay flag for the next cycle
  a_r9_delay_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_any && last_is_branch) |=> delay_q);

  // R10: a taken indication always arms the target flag
  a_r10_target_armed: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> target_q);

endmodule

// File: rtl/pair_issue_checker.sv
module pair_issue_checker
  import issue_pair_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter int ADDR_W  = 30
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         slot_valid,
  input  logic [1:0][CLS_W-1:0]              slot_class,
  input  logic [1:0]                         slot_store,
  input  logic [1:0]                         int_rd_vld,
  input  logic [1:0][REG_W-1:0]              int_rd,
  input  logic [1:0][NUM_SRC-1:0]            int_rs_vld,
  input  logic [1:0][NUM_SRC-1:0][REG_W-1:0] int_rs,
  input  logic [1:0][1:0]                    fp_rd_words,
  input  logic [1:0][REG_W-1:0]              fp_rd,
  input  logic [1:0][NUM_SRC-1:0][1:0]       fp_rs_words,
  input  logic [1:0][NUM_SRC-1:0][REG_W-1:0] fp_rs,
  input  logic [1:0]                         carry_set,
  input  logic [1:0]                         carry_use,
  input  logic [1:0][ADDR_W-1:0]             slot_addr,
  input  logic                               branch_taken,
  output logic                               issue_both,
  output logic                               issue_first
);

  logic class_ok;
  logic raw_hit, half_hit, target_hit, carry_hit;
  logic delay_q, target_q;
  logic solo_delay, solo_target;
  logic pair_ok;
  logic last_is_branch;

  pair_class_matrix u_matrix (
    .cls_old   (slot_class[0]),
    .cls_young (slot_class[1]),
    .class_ok  (class_ok)
  );

  pair_hazard_unit #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_hazard (
    .cls         (slot_class),
    .store       (slot_store),
    .int_rd_vld  (int_rd_vld),
    .int_rd      (int_rd),
    .int_rs_vld  (int_rs_vld),
    .int_rs      (int_rs),
    .fp_rd_words (fp_rd_words),
    .fp_rd       (fp_rd),
    .fp_rs_words (fp_rs_words),
    .fp_rs       (fp_rs),
    .carry_set   (carry_set),
    .carry_use   (carry_use),
    .raw_hit     (raw_hit),
    .half_hit    (half_hit),
    .target_hit  (target_hit),
    .carry_hit   (carry_hit)
  );

  assign solo_delay  = delay_q;
  assign solo_target = target_q && slot_addr[0][0];

  assign pair_ok = slot_valid[1] && class_ok && !raw_hit && !half_hit &&
                   !target_hit && !carry_hit && !solo_delay && !solo_target;

  assign issue_both  = slot_valid[0] && pair_ok;
  assign issue_first = slot_valid[0] && !pair_ok;

  assign last_is_branch = issue_both ? is_branch(slot_class[1]) : is_branch(slot_class[0]);

  issue_slot_state u_state (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_any      (slot_valid[0]),
    .last_is_branch (last_is_branch),
    .branch_taken   (branch_taken),
    .delay_q        (delay_q),
    .target_q       (target_q)
  );

  logic unused_addr_bits;
  assign unused_addr_bits = ^{slot_addr[1], slot_addr[0][ADDR_W-1:1]};

  a_r1_pair_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    issue_both |-> (&slot_valid));

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_both && issue_first));

  a_r1_first_needs_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    issue_first |-> slot_valid[0]);

  a_r3_sys_never_paired: assert property (@(posedge clk) disable iff (!rst_n)
    issue_both |-> (slot_class[0] != IC_SYS && slot_class[1] != IC_SYS));

  a_r8_carry_split: assert property (@(posedge clk) disable iff (!rst_n)
    issue_both |-> !((carry_set[0] && carry_use[1]) || (carry_set[1] && carry_use[0])));

  a_r9_after_lone_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_first && is_branch(slot_class[0])) |=> !issue_both);

  a_r9_after_paired_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_both && is_branch(slot_class[1])) |=> !issue_both);

  a_r10_odd_target_alone: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> !(issue_both && slot_addr[0][0]));

endmodule

// File: tb/pair_issue_checker_test.sv
module pair_issue_checker_test;

  localparam int REG_W  = 5;
  localparam int NS     = 2;
  localparam int ADDR_W = 30;
  localparam time HALF  = 10ns;

  logic                          clk = 1'b0;
  logic                          rst_n;
  logic [1:0]                    slot_valid;
  logic [1:0][3:0]               slot_class;
  logic [1:0]                    slot_store;
  logic [1:0]                    int_rd_vld;
  logic [1:0][REG_W-1:0]         int_rd;
  logic [1:0][NS-1:0]            int_rs_vld;
  logic [1:0][NS-1:0][REG_W-1:0] int_rs;
  logic [1:0][1:0]               fp_rd_words;
  logic [1:0][REG_W-1:0]         fp_rd;
  logic [1:0][NS-1:0][1:0]       fp_rs_words;
  logic [1:0][NS-1:0][REG_W-1:0] fp_rs;
  logic [1:0]                    carry_set, carry_use;
  logic [1:0][ADDR_W-1:0]        slot_addr;
  logic                          branch_taken;
  logic                          issue_both, issue_first;

  int errors = 0;
  int checks = 0;
  logic m_delay = 1'b0;
  logic m_target = 1'b0;

  always #HALF clk = ~clk;

  pair_issue_checker #(.REG_W(REG_W), .NUM_SRC(NS), .ADDR_W(ADDR_W)) uut (.*);

  function automatic logic may_follow(input int o, input int y);
    case (o)
      0: return y inside {1, 2, 3, 4, 5, 6};
      1: return y inside {0, 2, 3, 4, 6};
      2: return y inside {0, 1, 2, 3, 4, 6, 7};
      3: return y inside {0, 1, 2, 7};
      4: return y == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_load(input int s);
    return slot_class[s] == 4'd1 && !slot_store[s];
  endfunction

  function automatic logic model_pair(output string why);
    why = "R2";
    if (!slot_valid[0] || !slot_valid[1]) begin why = "R1"; return 1'b0; end
    if (slot_class[0] == 4'd8 || slot_class[1] == 4'd8) begin why = "R3"; return 1'b0; end
    if (!may_follow(int'(slot_class[0]), int'(slot_class[1]))) begin why = "R2"; return 1'b0; end
    for (int k = 0; k < NS; k++)
      if (int_rd_vld[0] && int_rs_vld[1][k] && int_rd[0] == int_rs[1][k]) begin
        why = "R4"; return 1'b0;
      end
    if (!(slot_class[0] == 4'd0 && slot_class[1] == 4'd1 && slot_store[1]))
      for (int k = 0; k < NS; k++)
        if (fp_rs[1][k] == fp_rd[0] && (fp_rs_words[1][k] & fp_rd_words[0]) != 2'b00) begin
          why = "R5"; return 1'b0;
        end
    for (int a = 0; a < 2; a++) begin
      if (is_load(a) && slot_class[1-a] == 4'd0 &&
          (fp_rd_words[a] == 2'b01 || fp_rd_words[a] == 2'b10))
        for (int k = 0; k < NS; k++)
          if (fp_rs[1-a][k] == fp_rd[a] && (fp_rs_words[1-a][k] & (2'b11 ^ fp_rd_words[a])) != 2'b00) begin
            why = "R6"; return 1'b0;
          end
      if (is_load(a) && slot_class[1-a] == 4'd0 && fp_rd_words[a] != 2'b00 &&
          fp_rd_words[1-a] != 2'b00 && fp_rd[a] == fp_rd[1-a]) begin
        why = "R7"; return 1'b0;
      end
    end
    if ((carry_set[0] && carry_use[1]) || (carry_use[0] && carry_set[1])) begin why = "R8"; return 1'b0; end
    if (m_delay) begin why = "R9"; return 1'b0; end
    if (m_target && slot_addr[0][0]) begin why = "R10"; return 1'b0; end
    return 1'b1;
  endfunction

  task automatic clear_all();
    slot_valid = '0; slot_class = '0; slot_store = '0;
    int_rd_vld = '0; int_rd = '0; int_rs_vld = '0; int_rs = '0;
    fp_rd_words = '0; fp_rd = '0; fp_rs_words = '0; fp_rs = '0;
    carry_set = '0; carry_use = '0; slot_addr = '0; branch_taken = 1'b0;
  endtask

  task automatic pair_of(input int c0, input int c1);
    clear_all();
    slot_valid = 2'b11;
    slot_class[0] = 4'(c0);
    slot_class[1] = 4'(c1);
    slot_addr[0] = 30'd8;
    slot_addr[1] = 30'd9;
  endtask

  // Called just after a falling edge with inputs set; checks, then advances.
  task automatic run(input string tag);
    string why;
    logic  eb, ef, last_br;
    #2ns;
    eb = model_pair(why);
    ef = slot_valid[0] && !eb;
    if (!slot_valid[0]) why = "R1";
    checks++;
    if (issue_both !== eb || issue_first !== ef) begin
      errors++;
      $display("FAIL %s (rule %s): both/first = %b%b, expected %b%b", tag, why,
               issue_both, issue_first, eb, ef);
    end
    last_br = eb ? (slot_class[1] inside {4'd5, 4'd6}) : (slot_class[0] inside {4'd5, 4'd6});
    if (slot_valid[0]) m_delay = last_br;
    if (branch_taken) m_target = 1'b1;
    else if (slot_valid[0]) m_target = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: flags clear after reset; odd address pair issues together
    pair_of(2, 2); slot_addr[0] = 30'd7; run("R11 reset state");
    // R1
    pair_of(2, 2); slot_valid = 2'b01; run("R1 lone older slot");
    clear_all(); run("R1 empty window");
    // R2
    pair_of(2, 2); run("R2 int+int");
    pair_of(3, 6); run("R2 shift+branch refused");
    pair_of(4, 0); run("R2 nullifier+fp op");
    pair_of(4, 2); run("R2 nullifier+int refused");
    // R3
    pair_of(2, 8); run("R3 sys younger");
    pair_of(8, 0); run("R3 sys older");
    // R4
    pair_of(2, 2); int_rd_vld[0] = 1; int_rd[0] = 5'd3; int_rs_vld[1][1] = 1; int_rs[1][1] = 5'd3;
    run("R4 int dependency");
    pair_of(2, 2); int_rd_vld[0] = 1; int_rd[0] = 5'd3; int_rs_vld[1][1] = 1; int_rs[1][1] = 5'd4;
    run("R4 independent regs pair");
    // R5
    pair_of(0, 0); fp_rd_words[0] = 2'b11; fp_rd[0] = 5'd2; fp_rs_words[1][0] = 2'b01; fp_rs[1][0] = 5'd2;
    run("R5 fp dependency");
    pair_of(0, 1); slot_store[1] = 1; fp_rd_words[0] = 2'b11; fp_rd[0] = 5'd2;
    fp_rs_words[1][0] = 2'b11; fp_rs[1][0] = 5'd2;
    run("R5 store of result pairs");
    pair_of(0, 0); fp_rd_words[0] = 2'b01; fp_rd[0] = 5'd2; fp_rs_words[1][0] = 2'b10; fp_rs[1][0] = 5'd2;
    run("R5 disjoint words pair");
    // R6
    pair_of(1, 0); fp_rd_words[0] = 2'b01; fp_rd[0] = 5'd4; fp_rs_words[1][1] = 2'b10; fp_rs[1][1] = 5'd4;
    run("R6 load low, op reads high");
    pair_of(0, 1); fp_rd_words[1] = 2'b10; fp_rd[1] = 5'd6; fp_rs_words[0][0] = 2'b01; fp_rs[0][0] = 5'd6;
    run("R6 op first, load second");
    // R7
    pair_of(0, 1); fp_rd_words[0] = 2'b11; fp_rd[0] = 5'd5; fp_rd_words[1] = 2'b11; fp_rd[1] = 5'd5;
    run("R7 same fp target");
    // R8
    pair_of(2, 2); carry_set[0] = 1; carry_use[1] = 1; run("R8 carry older to younger");
    pair_of(2, 2); carry_use[0] = 1; carry_set[1] = 1; run("R8 carry younger sets");
    // R9
    pair_of(2, 6); run("R9 int+branch pairs");
    pair_of(2, 2); run("R9 delay slot alone");
    pair_of(2, 2); run("R9 flag cleared");
    // R10 overlapping with R9
    pair_of(6, 2); slot_valid = 2'b01; run("R9 lone branch");
    pair_of(2, 2); branch_taken = 1; run("R9 delay slot while taken");
    pair_of(2, 2); slot_addr[0] = 30'd11; run("R10 odd target alone");
    pair_of(2, 2); slot_addr[0] = 30'd11; run("R10 flag consumed");
    pair_of(6, 2); slot_valid = 2'b01; run("R9 lone branch again");
    pair_of(2, 2); branch_taken = 1; run("R9 delay slot again");
    pair_of(2, 2); slot_addr[0] = 30'd12; run("R10 even target pairs");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      clear_all();
      for (int s = 0; s < 2; s++) begin
        slot_valid[s]  = ($urandom_range(0, 9) != 0);
        slot_class[s]  = 4'($urandom_range(0, 8));
        slot_store[s]  = 1'($urandom_range(0, 1));
        int_rd_vld[s]  = 1'($urandom_range(0, 1));
        int_rd[s]      = 5'($urandom_range(0, 3));
        fp_rd_words[s] = 2'($urandom_range(0, 3));
        fp_rd[s]       = 5'($urandom_range(0, 3));
        carry_set[s]   = ($urandom_range(0, 4) == 0);
        carry_use[s]   = ($urandom_range(0, 4) == 0);
        slot_addr[s]   = 30'($urandom);
        for (int k = 0; k < NS; k++) begin
          int_rs_vld[s][k]  = 1'($urandom_range(0, 1));
          int_rs[s][k]      = 5'($urandom_range(0, 3));
          fp_rs_words[s][k] = 2'($urandom_range(0, 3));
          fp_rs[s][k]       = 5'($urandom_range(0, 3));
        end
      end
      branch_taken = ($urandom_range(0, 9) == 0);
      run("R1 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule